// File: doc/BRIEF.md
# Shared-Pad GPIO Multiplexer with Wake and Event Logic

This block sits between a bank of general-purpose pins and the functional logic that shares their pads. For each pin, a selection bit decides whether the pad carries a functional signal or acts as a plain GPIO. In GPIO mode a direction register sets the output enable and an output register sets the driven level. One pin has three possible uses, settled by a fixed priority: a speaker output, a device-monitor input, and a plain GPIO.

The selection, direction and output registers sit in an always-powered domain with their own resume reset. A bus reset does not disturb them, so the pin set-up survives suspend. The configuration, event-enable, routing and status registers are cleared by the bus reset. Pad inputs pass through a two-flop synchronizer. A rising edge on an eligible pin sets a sticky status bit and sends a one-cycle pulse toward the SCI or SMI handler. Most such events also request a system wake. Which pins are eligible depends on whether each pin is in functional or GPIO mode.

Software reaches the block through a 32-bit word-addressed write port and a registered read port with one cycle of latency.

Top module: `gpio_pinmux`

## Requirements
- R1: After both resets, the register read-back is as follows. The output register (address 0) reads 0. The direction register (address 1, bit = 1 means output) reads 0. The selection register (address 2) reads all ones. The configuration register (address 3), status (address 4), event enable (address 5) and routing (address 6) all read 0. Reads return on `rdata` one clock after `addr` is presented.
- R2: Each pin outside the configuration group and other than pin 14 is controlled by its selection bit. When that bit is 1, the pin is functional: `pad_out`/`pad_oe` follow `func_out`/`func_oe` and the direction bit has no effect. When the bit is 0, the pin is a GPIO.
- R3: Pins 24 to 27 form the configuration group. Each is functional when the matching bit of the configuration register is 1 and a GPIO when that bit is 0, which is the reset value.
- R4: A GPIO pin drives `pad_oe` from its direction bit and `pad_out` from its output bit. The pads are registered and change one clock after the register write.
- R5: Pin 14 uses a fixed priority. With selection bit 14 at 1, it is a speaker output (`pad_oe`=1, `pad_out`=`spk_i`). Otherwise, with configuration bit 31 at 1, it is a monitor input (`pad_oe`=0, `pad_out`=0). Otherwise it is a GPIO.
- R6: A bus reset on its own clears the configuration, enable, routing and status registers. It leaves the output, direction and selection registers unchanged.
- R7: Address 7 returns the pad levels after a two-flop synchronizer. A pad change becomes readable three clocks later.
- R8: In GPIO mode, pins 0, 1, 4, 6, 9, 17, 18 and 20 are event-capable. A rising edge on such a pin, with its enable bit set, produces a one-cycle pulse and sets its status bit. The pulse goes on `sci_o` when the routing bit is 0 and on `smi_o` when it is 1. With the enable bit clear, nothing happens.
- R9: In functional mode, only pins 0, 10 and 11 are event-capable, acting as resume inputs. In that mode, pins 1, 4, 6, 9, 17, 18 and 20 raise nothing.
- R10: Every event also pulses `wake_o`, except an event from pin 6.
- R11: In monitor mode, `mon_o` carries the synchronized level of pin 14, registered. In every other mode it is 0.
- R12: Writing 1 to a status bit clears it. If an event lands in the same cycle as the clear, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_rsm | input | 1 | Always-on resume reset, synchronous, active high |
| rst_bus | input | 1 | Bus reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| func_out | input | 32 | Functional output values |
| func_oe | input | 32 | Functional output enables |
| spk_i | input | 1 | Speaker signal for pin 14 |
| mon_o | output | 1 | Device-monitor level from pin 14 |
| sci_o | output | 1 | SCI event pulse |
| smi_o | output | 1 | SMI event pulse |
| wake_o | output | 1 | Wake request pulse |

## Verification
The pad multiplexer is driven with walking-one and alternating patterns on the output and direction registers, with every pin in GPIO mode, so that a crossed bit or a swapped output/enable path shows up. The same patterns are then repeated with the pins in functional mode and the direction register toggled, to show that direction has no effect there. The event logic is swept over all 32 pins, once in GPIO mode and once in functional mode, with alternating routing bits. This separates the eligible pins from the rest, SCI from SMI, and pin 6 from the other wake sources. The three uses of pin 14, the bus-only reset and the write-one-to-clear status each get directed sequences.

// File: rtl/gpio_pinmux_pkg.sv
package gpio_pinmux_pkg;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_OUT   = 3'd0;
  localparam logic [AW-1:0] A_DIR   = 3'd1;
  localparam logic [AW-1:0] A_SEL   = 3'd2;
  localparam logic [AW-1:0] A_CFG   = 3'd3;
  localparam logic [AW-1:0] A_STAT  = 3'd4;
  localparam logic [AW-1:0] A_EN    = 3'd5;
  localparam logic [AW-1:0] A_ROUTE = 3'd6;
  localparam logic [AW-1:0] A_IN    = 3'd7;
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pinmux_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_rsm,
  input  logic            rst_bus,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [NPIN-1:0] wdata,
  input  logic [NPIN-1:0] ev_set,
  input  logic [NPIN-1:0] sync_in,
  output logic [NPIN-1:0] rdata,
  output logic [NPIN-1:0] out_q,
  output logic [NPIN-1:0] dir_q,
  output logic [NPIN-1:0] sel_q,
  output logic [NPIN-1:0] cfg_q,
  output logic [NPIN-1:0] en_q,
  output logic [NPIN-1:0] route_q,
  output logic [NPIN-1:0] stat_q
);
  logic            wr_ok;
  logic [NPIN-1:0] clr_mask;
  logic [NPIN-1:0] rd_mux;

  assign wr_ok    = wr_en && !rst_bus;
  assign clr_mask = (wr_ok && addr == A_STAT) ? wdata : '0;

  // always-on domain
  always_ff @(posedge clk) begin
    if (rst_rsm) begin
      out_q <= '0;
      dir_q <= '0;
      sel_q <= '1;
    end else if (wr_ok) begin
      if (addr == A_OUT) out_q <= wdata;
      if (addr == A_DIR) dir_q <= wdata;
      if (addr == A_SEL) sel_q <= wdata;
    end
  end

  always_comb begin
    case (addr)
      A_OUT:   rd_mux = out_q;
      A_DIR:   rd_mux = dir_q;
      A_SEL:   rd_mux = sel_q;
      A_CFG:   rd_mux = cfg_q;
      A_STAT:  rd_mux = stat_q;
      A_EN:    rd_mux = en_q;
      A_ROUTE: rd_mux = route_q;
      default: rd_mux = sync_in;
    endcase
  end

  // bus domain
  always_ff @(posedge clk) begin
    if (rst_bus) begin
      cfg_q   <= '0;
      en_q    <= '0;
      route_q <= '0;
      stat_q  <= '0;
      rdata   <= '0;
    end else begin
      if (wr_ok && addr == A_CFG)   cfg_q   <= wdata;
      if (wr_ok && addr == A_EN)    en_q    <= wdata;
      if (wr_ok && addr == A_ROUTE) route_q <= wdata;
      stat_q <= (stat_q & ~clr_mask) | ev_set;
      rdata  <= rd_mux;
    end
  end

  // R6
  keep_rsm_chk: assert property (@(posedge clk) disable iff (rst_rsm)
    rst_bus |=> (out_q == $past(out_q) && dir_q == $past(dir_q) && sel_q == $past(sel_q)));

  // R12
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst_bus)
    (wr_en && addr == A_STAT) |=> ((stat_q & $past(wdata & ~ev_set)) == '0));
endmodule

// File: rtl/gpio_mux.sv
module gpio_mux #(
  parameter int              NPIN    = 32,
  parameter logic [NPIN-1:0] CFG_GRP = 32'h0F00_0000,
  parameter int              TRI_PIN = 14,
  parameter int              MON_BIT = 31
) (
  input  logic            clk,
  input  logic            rst_bus,
  input  logic [NPIN-1:0] out_q,
  input  logic [NPIN-1:0] dir_q,
  input  logic [NPIN-1:0] sel_q,
  input  logic [NPIN-1:0] cfg_q,
  input  logic [NPIN-1:0] func_out,
  input  logic [NPIN-1:0] func_oe,
  input  logic            spk_i,
  input  logic [NPIN-1:0] sync_in,
  output logic [NPIN-1:0] fsel,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic            mon_o
);
  localparam logic [NPIN-1:0] TRI_MASK = NPIN'(1) << TRI_PIN;

  logic            spk_sel;
  logic            mon_sel;
  logic [NPIN-1:0] nx_out;
  logic [NPIN-1:0] nx_oe;

  // speaker outranks monitor, monitor outranks GPIO
  assign spk_sel = sel_q[TRI_PIN];
  assign mon_sel = !sel_q[TRI_PIN] && cfg_q[MON_BIT];

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    if (i == TRI_PIN) begin : g_tri
      assign fsel[i]   = spk_sel | mon_sel;
      assign nx_out[i] = spk_sel ? spk_i : (mon_sel ? 1'b0 : out_q[i]);
      assign nx_oe[i]  = spk_sel ? 1'b1  : (mon_sel ? 1'b0 : dir_q[i]);
    end else begin : g_std
      if (CFG_GRP[i]) begin : g_cfg
        assign fsel[i] = cfg_q[i];
      end else begin : g_sel
        assign fsel[i] = sel_q[i];
      end
      assign nx_out[i] = fsel[i] ? func_out[i] : out_q[i];
      assign nx_oe[i]  = fsel[i] ? func_oe[i]  : dir_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_bus) begin
      pad_out <= '0;
      pad_oe  <= '0;
      mon_o   <= 1'b0;
    end else begin
      pad_out <= nx_out;
      pad_oe  <= nx_oe;
      mon_o   <= mon_sel & sync_in[TRI_PIN];
    end
  end

  // R5
  spk_drive_chk: assert property (@(posedge clk) disable iff (rst_bus)
    spk_sel |=> (pad_oe[TRI_PIN] && pad_out[TRI_PIN] == $past(spk_i)));

  // R2
  func_pass_chk: assert property (@(posedge clk) disable iff (rst_bus)
    1'b1 |=> (((pad_oe ^ $past(func_oe)) & $past(fsel & ~TRI_MASK)) == '0));
endmodule

// File: rtl/gpio_event.sv
module gpio_event #(
  parameter int              NPIN     = 32,
  parameter logic [NPIN-1:0] EVT_GPIO = 32'h0016_0253,
  parameter logic [NPIN-1:0] EVT_FUNC = 32'h0000_0C01,
  parameter logic [NPIN-1:0] NO_WAKE  = 32'h0000_0040
) (
  input  logic            clk,
  input  logic            rst_bus,
  input  logic [NPIN-1:0] pad_in,
  input  logic [NPIN-1:0] fsel,
  input  logic [NPIN-1:0] en_q,
  input  logic [NPIN-1:0] route_q,
  output logic [NPIN-1:0] sync_in,
  output logic [NPIN-1:0] ev,
  output logic            sci_o,
  output logic            smi_o,
  output logic            wake_o
);
  logic [NPIN-1:0] s1;
  logic [NPIN-1:0] prev;
  logic [NPIN-1:0] elig;

  always_ff @(posedge clk) begin
    if (rst_bus) begin
      s1      <= '0;
      sync_in <= '0;
      prev    <= '0;
    end else begin
      s1      <= pad_in;
      sync_in <= s1;
      prev    <= sync_in;
    end
  end

  assign elig = (EVT_GPIO & ~fsel) | (EVT_FUNC & fsel);
  assign ev   = sync_in & ~prev & elig & en_q;

  always_ff @(posedge clk) begin
    if (rst_bus) begin
      sci_o  <= 1'b0;
      smi_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      sci_o  <= |(ev & ~route_q);
      smi_o  <= |(ev &  route_q);
      wake_o <= |(ev & ~NO_WAKE);
    end
  end

  // R10
  no_wake_chk: assert property (@(posedge clk) disable iff (rst_bus)
    (ev != '0 && (ev & ~NO_WAKE) == '0) |=> !wake_o);
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_pinmux_pkg::*;
#(
  parameter int              NPIN     = 32,
  parameter logic [NPIN-1:0] CFG_GRP  = 32'h0F00_0000,
  parameter int              TRI_PIN  = 14,
  parameter int              MON_BIT  = 31,
  parameter logic [NPIN-1:0] EVT_GPIO = 32'h0016_0253,
  parameter logic [NPIN-1:0] EVT_FUNC = 32'h0000_0C01,
  parameter logic [NPIN-1:0] NO_WAKE  = 32'h0000_0040
) (
  input  logic            clk,
  input  logic            rst_rsm,
  input  logic            rst_bus,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  input  logic [NPIN-1:0] func_out,
  input  logic [NPIN-1:0] func_oe,
  input  logic            spk_i,
  output logic            mon_o,
  output logic            sci_o,
  output logic            smi_o,
  output logic            wake_o
);
  logic [NPIN-1:0] out_q, dir_q, sel_q, cfg_q, en_q, route_q, stat_q;
  logic [NPIN-1:0] sync_in, ev, fsel;

  gpio_regfile #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst_rsm(rst_rsm), .rst_bus(rst_bus), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .ev_set(ev), .sync_in(sync_in),
    .rdata(rdata), .out_q(out_q), .dir_q(dir_q), .sel_q(sel_q),
    .cfg_q(cfg_q), .en_q(en_q), .route_q(route_q), .stat_q(stat_q)
  );

  gpio_mux #(.NPIN(NPIN), .CFG_GRP(CFG_GRP), .TRI_PIN(TRI_PIN), .MON_BIT(MON_BIT)) u_mux (
    .clk(clk), .rst_bus(rst_bus), .out_q(out_q), .dir_q(dir_q),
    .sel_q(sel_q), .cfg_q(cfg_q), .func_out(func_out), .func_oe(func_oe),
    .spk_i(spk_i), .sync_in(sync_in), .fsel(fsel), .pad_out(pad_out),
    .pad_oe(pad_oe), .mon_o(mon_o)
  );

  gpio_event #(.NPIN(NPIN), .EVT_GPIO(EVT_GPIO), .EVT_FUNC(EVT_FUNC), .NO_WAKE(NO_WAKE)) u_evt (
    .clk(clk), .rst_bus(rst_bus), .pad_in(pad_in), .fsel(fsel),
    .en_q(en_q), .route_q(route_q), .sync_in(sync_in), .ev(ev),
    .sci_o(sci_o), .smi_o(smi_o), .wake_o(wake_o)
  );

  // R8
  event_stat_chk: assert property (@(posedge clk) disable iff (rst_bus)
    (sci_o || smi_o) |-> (stat_q != '0));
endmodule

// File: tb/sim_gpio_pinmux.sv
`timescale 1ns/1ps
module sim_gpio_pinmux;
  logic        clk = 1'b0;
  logic        rst_rsm = 1'b1, rst_bus = 1'b1, wr_en = 1'b0, spk_i = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, pad_in = '0, func_out = '0, func_oe = '0;
  logic [31:0] rdata, pad_out, pad_oe;
  logic        mon_o, sci_o, smi_o, wake_o;
  int nchk = 0, nfail = 0;

  localparam logic [31:0] EVT_G = 32'h0016_0253;
  localparam logic [31:0] EVT_F = 32'h0000_0C01;

  always #2 clk = ~clk;

  gpio_pinmux u0 (
    .clk(clk), .rst_rsm(rst_rsm), .rst_bus(rst_bus), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .func_out(func_out),
    .func_oe(func_oe), .spk_i(spk_i), .mon_o(mon_o), .sci_o(sci_o),
    .smi_o(smi_o), .wake_o(wake_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // pad model from the requirements
  task automatic model(input logic [31:0] o, d, s, c, output logic [31:0] po, poe);
    for (int i = 0; i < 32; i++) begin
      logic f;
      if (i == 14) begin
        if (s[14]) begin po[i] = spk_i; poe[i] = 1'b1; end
        else if (c[31]) begin po[i] = 1'b0; poe[i] = 1'b0; end
        else begin po[i] = o[i]; poe[i] = d[i]; end
      end else begin
        f = (i >= 24 && i <= 27) ? c[i] : s[i];
        po[i]  = f ? func_out[i] : o[i];
        poe[i] = f ? func_oe[i]  : d[i];
      end
    end
  endtask

  task automatic pads(input string req, input logic [31:0] o, d, s, c);
    logic [31:0] po, poe;
    wait_n(2);
    model(o, d, s, c, po, poe);
    check(req, pad_out, po);
    check(req, pad_oe, poe);
  endtask

  task automatic setup(input logic [31:0] o, d, s, c);
    wr(3'd0, o); wr(3'd1, d); wr(3'd2, s); wr(3'd3, c);
  endtask

  task automatic ev_sweep(input logic funcmode);
    logic [31:0] v;
    for (int i = 0; i < 32; i++) begin
      int ns, nm, nw;
      logic el;
      el = funcmode ? EVT_F[i] : EVT_G[i];
      ns = 0; nm = 0; nw = 0;
      @(negedge clk); pad_in[i] = 1'b1;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        ns += int'(sci_o); nm += int'(smi_o); nw += int'(wake_o);
      end
      // R8 R9 routing alternates, odd pins to SMI
      check(funcmode ? "R9 sci" : "R8 sci", ns, (el && i % 2 == 0) ? 1 : 0);
      check(funcmode ? "R9 smi" : "R8 smi", nm, (el && i % 2 == 1) ? 1 : 0);
      // R10
      check("R10 wake", nw, (el && i != 6) ? 1 : 0);
      rd(3'd4, v);
      check(funcmode ? "R9 stat" : "R8 stat", v, el ? (32'd1 << i) : 32'd0);
      wr(3'd4, 32'hFFFF_FFFF);
      rd(3'd4, v);
      check("R12 clear", v, 32'd0);
      @(negedge clk); pad_in[i] = 1'b0;
      wait_n(4);
    end
  endtask

  initial begin
    logic [31:0] v;
    wait_n(3);
    rst_rsm = 1'b0; rst_bus = 1'b0;
    // R1
    rd(3'd0, v); check("R1 out", v, 32'h0);
    rd(3'd1, v); check("R1 dir", v, 32'h0);
    rd(3'd2, v); check("R1 sel", v, 32'hFFFF_FFFF);
    rd(3'd3, v); check("R1 cfg", v, 32'h0);
    rd(3'd4, v); check("R1 stat", v, 32'h0);
    rd(3'd5, v); check("R1 en", v, 32'h0);
    rd(3'd6, v); check("R1 route", v, 32'h0);
    pads("R1 pads", 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0);

    // R4 walking patterns in GPIO mode
    for (int k = 0; k < 32; k++) begin
      logic [31:0] o, d;
      o = (32'd1 << k) ^ 32'h5A5A_0F0F;
      d = ~(32'd1 << ((k + 7) % 32));
      setup(o, d, 32'h0, 32'h0);
      pads("R4", o, d, 32'h0, 32'h0);
    end

    // R2 functional pins ignore direction
    func_out = 32'hC3C3_3C3C; func_oe = 32'h0FF0_A55A;
    setup(32'h1234_5678, 32'hFFFF_FFFF, 32'hFFFF_BFFF, 32'h0);
    pads("R2 dir1", 32'h1234_5678, 32'hFFFF_FFFF, 32'hFFFF_BFFF, 32'h0);
    wr(3'd1, 32'h0);
    pads("R2 dir0", 32'h1234_5678, 32'h0, 32'hFFFF_BFFF, 32'h0);
    func_out = ~func_out; func_oe = ~func_oe;
    pads("R2 func", 32'h1234_5678, 32'h0, 32'hFFFF_BFFF, 32'h0);

    // R3 configuration group
    setup(32'h0F00_0000, 32'h0500_0000, 32'h0, 32'h0);
    pads("R3 gpio", 32'h0F00_0000, 32'h0500_0000, 32'h0, 32'h0);
    wr(3'd3, 32'h0A00_0000);
    pads("R3 mix", 32'h0F00_0000, 32'h0500_0000, 32'h0, 32'h0A00_0000);

    // R5 three-way priority on pin 14
    spk_i = 1'b1;
    setup(32'h0, 32'h4000, 32'h4000, 32'h8000_0000);
    pads("R5 spk", 32'h0, 32'h4000, 32'h4000, 32'h8000_0000);
    spk_i = 1'b0;
    pads("R5 spk0", 32'h0, 32'h4000, 32'h4000, 32'h8000_0000);
    wr(3'd2, 32'h0);
    pads("R5 mon", 32'h0, 32'h4000, 32'h0, 32'h8000_0000);
    wr(3'd3, 32'h0);
    pads("R5 gpio", 32'h0, 32'h4000, 32'h0, 32'h0);

    // R11 monitor output
    wr(3'd3, 32'h8000_0000);
    @(negedge clk); pad_in[14] = 1'b1;
    wait_n(4);
    check("R11 mon1", mon_o, 1'b1);
    wr(3'd2, 32'h4000);
    wait_n(2);
    check("R11 spk", mon_o, 1'b0);
    wr(3'd2, 32'h0);
    @(negedge clk); pad_in[14] = 1'b0;
    wait_n(4);
    check("R11 mon0", mon_o, 1'b0);

    // R7 input read-back
    for (int k = 0; k < 4; k++) begin
      logic [31:0] p;
      p = 32'h9E37_79B9 * (k + 1);
      @(negedge clk); pad_in = p;
      wait_n(3);
      rd(3'd7, v);
      check("R7 in", v, p);
    end
    @(negedge clk); pad_in = '0;
    wait_n(4);

    // R8 enable gate
    setup(32'h0, 32'h0, 32'h0, 32'h0);
    wr(3'd6, 32'hAAAA_AAAA);
    @(negedge clk); pad_in[1] = 1'b1;
    wait_n(6);
    check("R8 gated smi", smi_o, 1'b0);
    rd(3'd4, v); check("R8 gated stat", v, 32'h0);
    @(negedge clk); pad_in[1] = 1'b0;
    wait_n(4);

    // R8 R10 GPIO sweep
    wr(3'd5, 32'hFFFF_FFFF);
    ev_sweep(1'b0);
    // R9 functional sweep
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'h0F00_0000);
    ev_sweep(1'b1);

    // R12 set wins over clear: clear issued in the event cycle
    setup(32'h0, 32'h0, 32'h0, 32'h0);
    @(negedge clk); pad_in[4] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 3'd4; wdata = 32'h10;
    @(negedge clk); wr_en = 1'b0;
    rd(3'd4, v); check("R12 set wins", v, 32'h10);
    @(negedge clk); pad_in[4] = 1'b0;
    wr(3'd4, 32'hFFFF_FFFF);

    // R6 bus reset only
    setup(32'hDEAD_BEEF, 32'h1357_9BDF, 32'h2468_ACE0, 32'h8F00_0000);
    wr(3'd5, 32'h1); wr(3'd6, 32'h3);
    @(negedge clk); rst_bus = 1'b1;
    wait_n(2);
    @(negedge clk); rst_bus = 1'b0;
    rd(3'd0, v); check("R6 out", v, 32'hDEAD_BEEF);
    rd(3'd1, v); check("R6 dir", v, 32'h1357_9BDF);
    rd(3'd2, v); check("R6 sel", v, 32'h2468_ACE0);
    rd(3'd3, v); check("R6 cfg", v, 32'h0);
    rd(3'd5, v); check("R6 en", v, 32'h0);
    rd(3'd6, v); check("R6 route", v, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule